// File: doc/BRIEF.md
# Immediate Nibble Streamer

This block serializes a 32-bit word held in a command onto one group of four output pins, one nibble at a time. A 32-bit phase accumulator sets the pace. A frequency value is added to it on every clock, and each carry out of the top bit moves the output on to the next nibble. A command gives the data word, the number of nibbles to send, the pin group to drive, an output-enable bit, an order bit and a lead-in bit. When the lead-in bit is set, the command sends zero placeholder nibbles. These delay the first real nibble so that it lines up against a clock started elsewhere.

If a command arrives while the block is idle, it starts on the next clock. If a command arrives while another is running, it waits in a single holding slot. It then starts on the same clock edge that ends the current command, so the output has no gap. A done flag is high only when neither the running command nor the waiting one has any nibbles left to send. Software waits on this flag.

Top module: `nib_stream`

## Requirements
- R1: After reset, `done` and `cmd_ready` are 1, and `pin_out` and `pin_oe` are all zero.
- R2: When `cmd_order` is 0, nibble k of the word is bits [4k+3:4k]. A word 0x12345678 therefore leaves as 8,7,6,5,4,3,2,1.
- R3: When `cmd_order` is 1, the two nibbles of each byte trade places. The same word leaves as 7,8,5,6,3,4,1,2.
- R4: A command sends exactly `cmd_count` nibbles, with 0 meaning 16. Nibble positions 8 and above send 0.
- R5: The frequency value F sets the length of every nibble, which is the number of clocks until the accumulator carries. F = 0x8000_0000 gives 2 clocks, 0x4000_0000 gives 4 clocks and 0x2000_0000 gives 8 clocks.
- R6: A command accepted while `done` is 1 shows its first nibble on the next clock, and `done` falls in that same clock.
- R7: A command accepted while another is running is held, and `cmd_ready` is 0 while it is held. It starts right after the last nibble of the running command, with no gap.
- R8: `done` returns to 1 only after both the running command and the held command have finished. It then stays at 1 until a new command arrives.
- R9: When `cmd_lead` is 1, every nibble of the command is 0, whatever the data word holds.
- R10: `pin_oe` drives 4'hF on the selected group only while a command is running with `cmd_pen` = 1. Otherwise `pin_oe` stays zero, even though data still appears on `pin_out`.
- R11: A frequency written while a command is running has no effect until the next command starts, whether that command starts from idle or from the holding slot.
- R12: `cmd_base` = g places the nibbles on `pin_out[4g+3:4g]`. All other pins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_wr | input | 1 | Write strobe for the frequency register |
| freq_val | input | 32 | Frequency value added to the accumulator on every clock |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_ready | output | 1 | Command can be accepted (holding slot empty) |
| cmd_word | input | 32 | Data word to serialize |
| cmd_count | input | 4 | Number of nibbles to send, with 0 meaning 16 |
| cmd_base | input | BASE_W (2) | Index of the pin group to drive |
| cmd_pen | input | 1 | Enables the output drivers of the group |
| cmd_order | input | 1 | Swaps the two nibbles within each byte |
| cmd_lead | input | 1 | Sends zero placeholder nibbles |
| pin_out | output | 4*GROUPS (16) | Pin data |
| pin_oe | output | 4*GROUPS (16) | Pin output enables |
| done | output | 1 | No command running and none held |

## Verification
On every cycle, the assertions check the handshake and the idle state. When the block is idle, its pins are quiet and `cmd_ready` is high. A command accepted while idle clears `done` on the next cycle, and `done` stays high when nothing is offered. The enable outputs are either all low or exactly one group of four. The nibble order, the number of clocks each nibble lasts, the lead-in zeros, the seamless handover between back-to-back commands and the point at which a new frequency is picked up all depend on long sequences. Only the bench shows these. It compares the pins on every cycle of each command with a stream it builds on its own.

// File: rtl/nib_pkg.sv
package nib_pkg;

  localparam int WORD_W  = 32;
  localparam int CNT_W   = 4;
  localparam int BASEF_W = 4;
  localparam int NIBS    = WORD_W / 4;

  typedef struct packed {
    logic [WORD_W-1:0]  word;
    logic [CNT_W-1:0]   count;
    logic [BASEF_W-1:0] base;
    logic               pen;
    logic               ord;
    logic               lead;
  } nib_cmd_t;

  // Nibble shown at position idx; positions past the word send zero.
  function automatic logic [3:0] nib_pick(input logic [WORD_W-1:0] word,
                                          input logic [CNT_W-1:0]  idx,
                                          input logic              ord,
                                          input logic              lead);
    logic [2:0] phys;
    phys = {idx[2:1], idx[0] ^ ord};
    if (lead || idx[3])
      return 4'h0;
    return word[phys*4 +: 4];
  endfunction

  // One accumulator step: carry in bit 32, new phase below it.
  function automatic logic [32:0] nco_step(input logic [31:0] acc,
                                           input logic [31:0] freq);
    return {1'b0, acc} + {1'b0, freq};
  endfunction

endpackage

// File: rtl/nib_rate.sv
module nib_rate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        reload,
  input  logic        run,
  input  logic [31:0] freq_in,
  output logic        tick
);
  import nib_pkg::*;

  logic [31:0] acc;
  logic [31:0] freq_act;
  logic [32:0] step;

  assign step = nco_step(acc, freq_act);
  assign tick = run & step[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      freq_act <= '0;
    end else if (restart) begin
      acc      <= '0;
      freq_act <= freq_in;
    end else if (run) begin
      acc <= step[31:0];
      if (reload)
        freq_act <= freq_in;
    end
  end
endmodule

// File: rtl/nib_seq.sv
module nib_seq (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  nib_pkg::nib_cmd_t  cmd_in,
  input  logic               tick,
  output logic               cmd_ready,
  output logic               active,
  output nib_pkg::nib_cmd_t  cur,
  output logic [3:0]         idx,
  output logic               start_idle,
  output logic               chain,
  output logic               last_nib
);
  import nib_pkg::*;

  nib_cmd_t held;
  logic     held_v;
  logic     accept;

  assign cmd_ready  = ~held_v;
  assign accept     = cmd_valid & cmd_ready;
  assign start_idle = accept & ~active;
  assign last_nib   = active & tick & (idx == cur.count - 4'd1);
  assign chain      = last_nib & (held_v | cmd_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      idx    <= '0;
      held   <= '0;
      held_v <= 1'b0;
    end else if (start_idle) begin
      active <= 1'b1;
      cur    <= cmd_in;
      idx    <= '0;
    end else if (active) begin
      if (last_nib) begin
        idx <= '0;
        if (held_v) begin
          cur    <= held;
          held_v <= 1'b0;
        end else if (cmd_valid) begin
          cur <= cmd_in;
        end else begin
          active <= 1'b0;
        end
      end else begin
        if (tick)
          idx <= idx + 4'd1;
        if (accept) begin
          held   <= cmd_in;
          held_v <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nib_pinmux.sv
module nib_pinmux #(
  parameter int GROUPS = 4,
  parameter int BASE_W = 2
) (
  input  logic                active,
  input  logic [BASE_W-1:0]   base,
  input  logic                pen,
  input  logic [3:0]          nib,
  output logic [4*GROUPS-1:0] pin_out,
  output logic [4*GROUPS-1:0] pin_oe
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic sel;
    assign sel = active && (base == BASE_W'(g));
    assign pin_out[4*g +: 4] = sel ? nib : 4'h0;
    assign pin_oe[4*g +: 4]  = (sel && pen) ? 4'hF : 4'h0;
  end
endmodule

// File: rtl/nib_stream.sv
module nib_stream #(
  parameter int GROUPS = 4,
  localparam int BASE_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int PINS   = 4 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freq_wr,
  input  logic [31:0]       freq_val,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_word,
  input  logic [3:0]        cmd_count,
  input  logic [BASE_W-1:0] cmd_base,
  input  logic              cmd_pen,
  input  logic              cmd_order,
  input  logic              cmd_lead,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              done
);
  import nib_pkg::*;

  logic [31:0] freq_reg;
  nib_cmd_t    cmd_in;
  nib_cmd_t    cur;
  logic [3:0]  idx;
  logic        active, tick, start_idle, chain, last_nib;
  logic [3:0]  nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      freq_reg <= '0;
    else if (freq_wr)
      freq_reg <= freq_val;
  end

  always_comb begin
    cmd_in       = '0;
    cmd_in.word  = cmd_word;
    cmd_in.count = cmd_count;
    cmd_in.base  = BASEF_W'(cmd_base);
    cmd_in.pen   = cmd_pen;
    cmd_in.ord   = cmd_order;
    cmd_in.lead  = cmd_lead;
  end

  nib_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_in(cmd_in),
    .tick(tick), .cmd_ready(cmd_ready), .active(active), .cur(cur),
    .idx(idx), .start_idle(start_idle), .chain(chain), .last_nib(last_nib)
  );

  nib_rate u_rate (
    .clk(clk), .rst_n(rst_n), .restart(start_idle), .reload(chain),
    .run(active), .freq_in(freq_reg), .tick(tick)
  );

  assign nib = nib_pick(cur.word, idx, cur.ord, cur.lead);

  nib_pinmux #(.GROUPS(GROUPS), .BASE_W(BASE_W)) u_mux (
    .active(active), .base(cur.base[BASE_W-1:0]), .pen(cur.pen),
    .nib(nib), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign done = ~active;
endmodule

// File: rtl/nib_stream_chk.sv
module nib_stream_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            done,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pin_out == '0 && pin_oe == '0));

  p_idle_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_valid) |=> !done);

  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cmd_valid) |=> done);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  p_one_group_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '0) || ($countones(pin_oe) == 4));

  p_oe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> !done);
endmodule

bind nib_stream nib_stream_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/nib_stream_bench.sv
module nib_stream_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freq_wr = 1'b0;
  logic [31:0] freq_val = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic [3:0]  cmd_count = '0;
  logic [1:0]  cmd_base = '0;
  logic        cmd_pen = 1'b0, cmd_order = 1'b0, cmd_lead = 1'b0;
  logic [15:0] pin_out, pin_oe;
  logic        done;

  always #4 clk = ~clk;

  nib_stream u_nib_stream (.*);

  int checks = 0, fails = 0;
  logic [15:0] exp_out [0:4095];
  logic [15:0] exp_oe  [0:4095];
  int n_exp;

  // second command and mid-run frequency write
  bit has2; logic [31:0] w2; logic [3:0] c2; logic [1:0] b2; bit pe2, o2, l2;
  int fw_at; logic [31:0] fw_val;

  function automatic logic [3:0] ref_nib(logic [31:0] w, int k, bit ord, bit lead);
    int sh;
    if (lead || k >= 8) return 4'h0;
    sh = 8 * (k / 2) + ((((k % 2) == 1) != ord) ? 4 : 0);
    return 4'((w >> sh) & 32'hF);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] w, logic [3:0] cnt, bit ord, bit lead, int p,
                      logic [1:0] base, bit pen);
    int n = (cnt == 0) ? 16 : int'(cnt);
    for (int k = 0; k < n; k++)
      for (int j = 0; j < p; j++) begin
        exp_out[n_exp] = 16'(ref_nib(w, k, ord, lead)) << (4 * base);
        exp_oe[n_exp]  = pen ? (16'hF << (4 * base)) : 16'h0;
        n_exp++;
      end
  endtask

  task automatic set_freq(logic [31:0] f);
    @(negedge clk); freq_wr = 1; freq_val = f;
    @(negedge clk); freq_wr = 0;
  endtask

  task automatic drive(logic [31:0] w, logic [3:0] cnt, logic [1:0] b, bit pe, bit o, bit l);
    cmd_valid = 1; cmd_word = w; cmd_count = cnt; cmd_base = b;
    cmd_pen = pe; cmd_order = o; cmd_lead = l;
  endtask

  // Issue first command (already pushed) and compare every cycle.
  task automatic run(string req, logic [31:0] w, logic [3:0] cnt, logic [1:0] b,
                     bit pe, bit o, bit l);
    int bad = 0; logic [15:0] ba = 0, be = 0;
    @(negedge clk); drive(w, cnt, b, pe, o, l);
    for (int s = 0; s <= n_exp; s++) begin
      @(negedge clk);
      if (s < n_exp) begin
        if (pin_out !== exp_out[s] || pin_oe !== exp_oe[s] || done !== 1'b0) begin
          if (bad == 0) begin ba = pin_out; be = exp_out[s]; end
          bad++;
        end
      end else begin
        check(done === 1'b1 && pin_oe == 0, {req, " done"}, {31'd0, done}, 32'd1);
      end
      if (has2 && s == 1)
        check(cmd_ready === 1'b0, "R7 ready low while held", {31'd0, cmd_ready}, 32'd0);
      cmd_valid = 0;
      if (has2 && s == 0) drive(w2, c2, b2, pe2, o2, l2);
      freq_wr = (s == fw_at);
      freq_val = fw_val;
    end
    freq_wr = 0;
    check(bad == 0, {req, " stream"}, {16'd0, ba}, {16'd0, be});
    has2 = 0; fw_at = -1; n_exp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    has2 = 0; fw_at = -1; fw_val = 0; n_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(done === 1 && cmd_ready === 1 && pin_out == 0 && pin_oe == 0,
          "R1 reset state", {pin_out, pin_oe}, 32'd0);

    // R2 default order, R5 quarter rate, R6 immediate start
    set_freq(32'h4000_0000);
    push(32'h1234_5678, 4'd8, 0, 0, 4, 2'd0, 1);
    run("R2 R5 R6 default order", 32'h1234_5678, 4'd8, 2'd0, 1, 0, 0);

    // R3 swapped order, R5 half rate
    set_freq(32'h8000_0000);
    push(32'h1234_5678, 4'd8, 1, 0, 2, 2'd1, 1);
    run("R3 R5 swapped order", 32'h1234_5678, 4'd8, 2'd1, 1, 1, 0);

    // R4 short count and count 0 = 16 with zero tail, R12 top group
    push(32'hCAFE_F00D, 4'd6, 0, 0, 2, 2'd3, 1);
    run("R4 R12 six nibbles", 32'hCAFE_F00D, 4'd6, 2'd3, 1, 0, 0);
    push(32'hA5A5_5A5A, 4'd0, 0, 0, 2, 2'd2, 1);
    run("R4 count zero", 32'hA5A5_5A5A, 4'd0, 2'd2, 1, 0, 0);

    // R10 pin enable off: data visible, oe stays low
    push(32'h9876_5432, 4'd5, 0, 0, 2, 2'd1, 0);
    run("R10 enable off", 32'h9876_5432, 4'd5, 2'd1, 0, 0, 0);

    // R9 lead-in followed by real data, R7 seamless, R8 done after both
    set_freq(32'h2000_0000);
    push(32'hFFFF_FFFF, 4'd3, 0, 1, 8, 2'd0, 1);
    push(32'h0000_00BE, 4'd2, 0, 0, 8, 2'd0, 1);
    has2 = 1; w2 = 32'h0000_00BE; c2 = 4'd2; b2 = 2'd0; pe2 = 1; o2 = 0; l2 = 0;
    run("R9 R7 R8 lead-in chain", 32'hFFFF_FFFF, 4'd3, 2'd0, 1, 0, 1);

    // R11 frequency written mid-command: no effect on current command
    set_freq(32'h4000_0000);
    push(32'h0F1E_2D3C, 4'd4, 0, 0, 4, 2'd2, 1);
    fw_at = 3; fw_val = 32'h8000_0000;
    run("R11 mid-command write", 32'h0F1E_2D3C, 4'd4, 2'd2, 1, 0, 0);

    // R11 held command picks up the new rate
    set_freq(32'h4000_0000);
    push(32'h0000_4321, 4'd4, 0, 0, 4, 2'd1, 1);
    push(32'h0000_8765, 4'd4, 1, 0, 2, 2'd3, 1);
    has2 = 1; w2 = 32'h0000_8765; c2 = 4'd4; b2 = 2'd3; pe2 = 1; o2 = 1; l2 = 0;
    fw_at = 2; fw_val = 32'h8000_0000;
    run("R11 R7 chained rate change", 32'h0000_4321, 4'd4, 2'd1, 1, 0, 0);

    // Random mix
    for (int i = 0; i < 24; i++) begin
      int lp = 1 + int'($urandom % 3);
      logic [31:0] w = $urandom;
      logic [3:0] cnt = 4'(1 + $urandom % 15);
      logic [1:0] b = 2'($urandom);
      bit pe = ($urandom % 4) != 0;
      bit o = 1'($urandom);
      bit l = ($urandom % 6) == 0;
      set_freq(32'h1 << (32 - lp));
      push(w, cnt, o, l, 1 << lp, b, pe);
      if ((i % 3) == 2) begin
        w2 = $urandom; c2 = 4'(1 + $urandom % 8); b2 = 2'($urandom);
        pe2 = 1; o2 = 1'($urandom); l2 = 0; has2 = (cnt * (1 << lp)) > 2;
        if (has2) push(w2, c2, o2, l2, 1 << lp, b2, pe2);
      end
      run("R2 R3 R4 R5 R7 random", w, cnt, b, pe, o, l);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule